// File: doc/BRIEF.md
# Reset Source Controller with Power-up Timer

This block merges the reset requests of a small device into one device-reset output. It also keeps a set of status flags that record which source caused the most recent reset. The sources are:

- a power-on detector;
- a main brown-out detector;
- a low-power brown-out detector;
- an external reset pin, which configuration can disable;
- watchdog pulses, one for expiry and one for a window violation.

All logic runs on the low-frequency clock `clk_lf`. The raw detector and pin inputs pass through two-flop synchronizers. The device reset is released on an edge of that clock.

After a power-on or brown-out condition goes away, an optional power-up timer holds the device in reset for a further `PWRT_CYCLES` clocks. The default is 2048, about 66 ms on a nominal low-frequency oscillator. When the device leaves programming mode, the block repeats the whole power-on sequence, including the flags and the delay. Software can set the active-low flags back to 1 through a write port; only their own cause clears them again.

Flag vector layout (`flags`), bit position and meaning:
- bit0: power-on cause, active low;
- bit1: brown-out cause, active low;
- bit2: pin cause, active low;
- bit3: watchdog cause, active low;
- bit4: time-out, active low;
- bit5: power-down, active low;
- bit6: watchdog window violation, 1 = window violation, 0 = expiry.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `por_raw` is high, `dev_rst` is 1 and `flags` is 7'b0111110 (bit0 = 0, bit6 = 0, all others 1).
- R2: `bor_comb` equals `bor_raw | (lpbor_raw & ~cfg_lpbor_off)`, combinationally. `cfg_lpbor_off` = 1 is the erased, disabled setting.
- R3: A high `bor_comb` sets `dev_rst` after the second clock edge. It clears flag bit1 after the third edge.
- R4: A low `pin_lvl` acts as a reset only while `cfg_pin_en` or `cfg_lvp` is 1. In that case `dev_rst` is set after the second edge and flag bit2 is cleared after the third edge. With both configuration bits at 0, the pin leaves `dev_rst` and bit2 unchanged.
- R5: A one-cycle `wdt_tmo` or `wdt_win` pulse makes `dev_rst` 1 for exactly the following cycle. After the same edge, bits 3 and 4 are 0 and bit5 is 1. Bit6 becomes 1 for a window violation and 0 for an expiry.
- R6: With `cfg_pwrt_off` = 0, `dev_rst` stays 1 for exactly `PWRT_CYCLES` cycles after the synchronized power-on or brown-out condition drops. With `cfg_pwrt_off` = 1, `dev_rst` falls at the second edge after `por_raw` or `bor_comb` falls.
- R7: The power-up delay starts only once the power-on and brown-out conditions are released. A brown-out during the delay restarts it from the beginning.
- R8: A one-cycle `prog_exit` pulse sets `dev_rst` after the next edge and restores the R1 flag value after the second edge. The delay then ends `PWRT_CYCLES` + 3 edges after the pulse, exactly as after a power-on.
- R9: Writing with `flag_wr_en` sets to 1 every flag among bits 0..5 whose data bit is 1. Data bits at 0 leave their flag unchanged, data bit6 is ignored, and a cause active in the same cycle overrides the write.
- R10: When causes coincide, only the highest updates flags. The order is power-on, then brown-out, then pin, then watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Low-frequency clock |
| por_raw | input | 1 | Power-on detector output, active high, asynchronous |
| bor_raw | input | 1 | Main brown-out detector output, active high |
| lpbor_raw | input | 1 | Low-power brown-out detector output, active high |
| pin_lvl | input | 1 | External reset pin level, low requests reset |
| wdt_tmo | input | 1 | Watchdog expiry pulse |
| wdt_win | input | 1 | Watchdog window-violation pulse |
| prog_exit | input | 1 | Pulse on leaving programming mode |
| cfg_lpbor_off | input | 1 | 1 disables the low-power brown-out path |
| cfg_pin_en | input | 1 | Pin reset enable |
| cfg_lvp | input | 1 | Low-voltage programming enable, also enables the pin reset |
| cfg_pwrt_off | input | 1 | 1 disables the power-up timer |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 7 | Flag write data, 1 sets a flag |
| dev_rst | output | 1 | Device reset, active high |
| bor_comb | output | 1 | Combined brown-out request |
| flags | output | 7 | Reset cause flags |

## Verification
The ports show a bad internal state quickly:
- A synchronizer stage that is stuck or missing moves the rise of `dev_rst` by a whole cycle. That is visible at the second edge after a source asserts.
- An off-by-one in the delay counter moves the fall of `dev_rst` one cycle away from edge `PWRT_CYCLES` + 2 after release.
- A wrong priority choice or a lost write corrupts one flag bit right after the edge that should have updated it.
- A watchdog reset that is held too long shows as `dev_rst` still high one cycle later.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int FLAG_W = 7;

    localparam int F_POR = 0;
    localparam int F_BOR = 1;
    localparam int F_PIN = 2;
    localparam int F_WDT = 3;
    localparam int F_TO  = 4;
    localparam int F_PD  = 5;
    localparam int F_WIN = 6;

    typedef logic [FLAG_W-1:0] flags_t;

    localparam flags_t FLAGS_AT_POR      = 7'b011_1110;
    localparam flags_t FLAGS_SW_SETTABLE = 7'b011_1111;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_BOR,
        CAUSE_PIN,
        CAUSE_WDT
    } cause_e;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic load_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        if (load_i) chain_d = {STAGES{RST_VAL}};
        else        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_pwrt.sv
module rsc_pwrt #(
    parameter int CYCLES = 2048
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic hold_i,
    input  logic en_i,
    output logic run_o
);
    localparam int          CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } pwrt_st_t;

    pwrt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.run = en_i;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/rsc_flags.sv
module rsc_flags
    import rsc_pkg::*;
(
    input  logic   clk_i,
    input  logic   arst_i,
    input  logic   por_i,
    input  logic   bor_i,
    input  logic   pin_i,
    input  logic   wdt_tmo_i,
    input  logic   wdt_win_i,
    input  logic   wr_en_i,
    input  flags_t wr_data_i,
    output flags_t flags_o
);
    typedef struct packed {
        flags_t flg;
    } flag_st_t;

    flag_st_t st_d, st_q;
    cause_e   cause;

    always_comb begin
        cause = CAUSE_NONE;
        if (bor_i)                       cause = CAUSE_BOR;
        else if (pin_i)                  cause = CAUSE_PIN;
        else if (wdt_tmo_i || wdt_win_i) cause = CAUSE_WDT;
    end

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.flg = FLAGS_AT_POR;
        end else begin
            if (wr_en_i) st_d.flg = st_q.flg | (wr_data_i & FLAGS_SW_SETTABLE);
            unique case (cause)
                CAUSE_BOR: st_d.flg[F_BOR] = 1'b0;
                CAUSE_PIN: st_d.flg[F_PIN] = 1'b0;
                CAUSE_WDT: begin
                    st_d.flg[F_WDT] = 1'b0;
                    st_d.flg[F_TO]  = 1'b0;
                    st_d.flg[F_PD]  = 1'b1;
                    st_d.flg[F_WIN] = wdt_win_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q.flg <= FLAGS_AT_POR;
        else        st_q     <= st_d;
    end

    assign flags_o = st_q.flg;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
#(
    parameter int PWRT_CYCLES = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_lf,
    input  logic              por_raw,
    input  logic              bor_raw,
    input  logic              lpbor_raw,
    input  logic              pin_lvl,
    input  logic              wdt_tmo,
    input  logic              wdt_win,
    input  logic              prog_exit,
    input  logic              cfg_lpbor_off,
    input  logic              cfg_pin_en,
    input  logic              cfg_lvp,
    input  logic              cfg_pwrt_off,
    input  logic              flag_wr_en,
    input  logic [FLAG_W-1:0] flag_wr_data,
    output logic              dev_rst,
    output logic              bor_comb,
    output logic [FLAG_W-1:0] flags
);
    typedef struct packed {
        logic wdt_rst;
    } top_st_t;

    top_st_t top_d, top_q;
    logic    por_s, bor_s, pin_s, pin_act, pwrt_run;

    assign bor_comb = bor_raw | (lpbor_raw & ~cfg_lpbor_off);

    // power-on release chain; leaving programming mode reloads it
    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
        .clk_i(clk_lf), .arst_i(por_raw), .load_i(prog_exit),
        .d_i(1'b0), .q_o(por_s)
    );

    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bor_sync (
        .clk_i(clk_lf), .arst_i(por_raw), .load_i(1'b0),
        .d_i(bor_comb), .q_o(bor_s)
    );

    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i(clk_lf), .arst_i(por_raw), .load_i(1'b0),
        .d_i(pin_lvl), .q_o(pin_s)
    );

    assign pin_act = ~pin_s & (cfg_pin_en | cfg_lvp);

    rsc_pwrt #(.CYCLES(PWRT_CYCLES)) u_pwrt (
        .clk_i(clk_lf), .arst_i(por_raw), .hold_i(por_s | bor_s),
        .en_i(~cfg_pwrt_off), .run_o(pwrt_run)
    );

    rsc_flags u_flags (
        .clk_i(clk_lf), .arst_i(por_raw), .por_i(por_s), .bor_i(bor_s),
        .pin_i(pin_act), .wdt_tmo_i(wdt_tmo), .wdt_win_i(wdt_win),
        .wr_en_i(flag_wr_en), .wr_data_i(flag_wr_data), .flags_o(flags)
    );

    always_comb begin
        top_d         = top_q;
        top_d.wdt_rst = wdt_tmo | wdt_win;
    end

    always_ff @(posedge clk_lf or posedge por_raw) begin
        if (por_raw) top_q <= '0;
        else         top_q <= top_d;
    end

    assign dev_rst = por_raw | por_s | bor_s | pin_act | pwrt_run | top_q.wdt_rst;
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk
    import rsc_pkg::*;
(
    input logic              clk_lf,
    input logic              por_raw,
    input logic              bor_raw,
    input logic              lpbor_raw,
    input logic              cfg_lpbor_off,
    input logic              wdt_tmo,
    input logic              wdt_win,
    input logic              prog_exit,
    input logic              flag_wr_en,
    input logic              por_s,
    input logic              bor_s,
    input logic              pin_act,
    input logic              dev_rst,
    input logic              bor_comb,
    input logic [FLAG_W-1:0] flags
);
    // R2
    lpbor_path_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (lpbor_raw && !cfg_lpbor_off) |-> bor_comb);

    // R2
    bor_quiet_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (!bor_raw && cfg_lpbor_off) |-> !bor_comb);

    // R3
    bor_flag_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (bor_s && !por_s) |=> !flags[F_BOR]);

    // R5
    wdt_rst_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (wdt_tmo || wdt_win) |=> dev_rst);

    // R8
    prog_exit_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        prog_exit |=> (dev_rst && por_s));

    // R9
    win_stable_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (!wdt_tmo && !wdt_win && !por_s) |=> $stable(flags[F_WIN]));

    // R10
    pin_prio_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        (pin_act && !bor_s && !por_s) |=> !flags[F_PIN]);

    // R10
    wdt_masked_chk: assert property (@(posedge clk_lf) disable iff (por_raw)
        ((pin_act || bor_s) && !por_s && !flag_wr_en) |=> $stable(flags[F_TO]));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk u_chk (
    .clk_lf(clk_lf), .por_raw(por_raw), .bor_raw(bor_raw), .lpbor_raw(lpbor_raw),
    .cfg_lpbor_off(cfg_lpbor_off), .wdt_tmo(wdt_tmo), .wdt_win(wdt_win),
    .prog_exit(prog_exit), .flag_wr_en(flag_wr_en), .por_s(por_s), .bor_s(bor_s),
    .pin_act(pin_act), .dev_rst(dev_rst), .bor_comb(bor_comb), .flags(flags)
);

// File: tb/rst_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_src_ctrl_tb_top;
    localparam int P = 32;

    logic       clk_lf = 1'b0;
    logic       por_raw = 1'b0, bor_raw = 1'b0, lpbor_raw = 1'b0, pin_lvl = 1'b1;
    logic       wdt_tmo = 1'b0, wdt_win = 1'b0, prog_exit = 1'b0;
    logic       cfg_lpbor_off = 1'b1, cfg_pin_en = 1'b1, cfg_lvp = 1'b0, cfg_pwrt_off = 1'b0;
    logic       flag_wr_en = 1'b0;
    logic [6:0] flag_wr_data = '0;
    logic       dev_rst, bor_comb;
    logic [6:0] flags;

    int checks = 0;
    int errors = 0;

    always #2.5 clk_lf = ~clk_lf;

    rst_src_ctrl #(.PWRT_CYCLES(P)) dut_i (
        .clk_lf(clk_lf), .por_raw(por_raw), .bor_raw(bor_raw), .lpbor_raw(lpbor_raw),
        .pin_lvl(pin_lvl), .wdt_tmo(wdt_tmo), .wdt_win(wdt_win), .prog_exit(prog_exit),
        .cfg_lpbor_off(cfg_lpbor_off), .cfg_pin_en(cfg_pin_en), .cfg_lvp(cfg_lvp),
        .cfg_pwrt_off(cfg_pwrt_off), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .dev_rst(dev_rst), .bor_comb(bor_comb), .flags(flags)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_lf);
    endtask

    task automatic wr(input logic [6:0] d);
        flag_wr_en = 1'b1; flag_wr_data = d;
        cyc(1);
        flag_wr_en = 1'b0; flag_wr_data = '0;
    endtask

    function automatic logic [6:0] next_flags(input logic [6:0] f, input logic we,
                                              input logic [6:0] d, input logic t, input logic w);
        logic [6:0] r = f;
        if (we) r = r | (d & 7'h3F);
        if (t || w) begin
            r[3] = 1'b0; r[4] = 1'b0; r[5] = 1'b1; r[6] = w;
        end
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] exp_f;
        void'($urandom(32'd4711));
        #1 por_raw = 1'b1;
        cyc(4);
        // R1 reset state
        check("R1 dev_rst in power-on", dev_rst, 1);
        check("R1 flags in power-on", flags, 7'h3E);

        // R6 power-up delay after power-on release
        por_raw = 1'b0;
        cyc(P + 1);
        check("R6 still held at P+1", dev_rst, 1);
        cyc(1);
        check("R6 released at P+2", dev_rst, 0);

        // R9 writes
        wr(7'h7F);
        check("R9 write sets bits 0..5 only", flags, 7'h3F);
        wr(7'h00);
        check("R9 zero write keeps flags", flags, 7'h3F);

        // R5 timeout and window violation
        wdt_tmo = 1'b1; cyc(1); wdt_tmo = 1'b0;
        check("R5 reset after timeout", dev_rst, 1);
        check("R5 flags after timeout", flags, 7'h27);
        cyc(1);
        check("R5 reset one cycle only", dev_rst, 0);
        wr(7'h3F);
        wdt_win = 1'b1; cyc(1); wdt_win = 1'b0;
        check("R5 flags after window violation", flags, 7'h67);
        wr(7'h3F);
        check("R9 write leaves bit6", flags, 7'h7F);

        // R5 R9 random writes and watchdog pulses
        exp_f = 7'h7F;
        for (int i = 0; i < 300; i++) begin
            logic we, t, w;
            logic [6:0] d;
            we = ($urandom % 4) == 0;
            d  = 7'($urandom);
            t  = ($urandom % 8) == 0;
            w  = !t && (($urandom % 8) == 0);
            flag_wr_en = we; flag_wr_data = d; wdt_tmo = t; wdt_win = w;
            exp_f = next_flags(exp_f, we, d, t, w);
            cyc(1);
            check("R9 random flags", flags, exp_f);
            check("R5 random reset pulse", dev_rst, t | w);
        end
        flag_wr_en = 1'b0; wdt_tmo = 1'b0; wdt_win = 1'b0;
        cyc(1);
        wr(7'h3F);

        // R4 pin enabled
        pin_lvl = 1'b0;
        cyc(1);
        check("R4 pin not yet synced", dev_rst, 0);
        cyc(1);
        check("R4 pin reset at second edge", dev_rst, 1);
        cyc(1);
        check("R4 pin flag cleared", flags[2], 0);
        wr(7'h04);
        check("R9 cause overrides write", flags[2], 0);
        pin_lvl = 1'b1;
        cyc(2);
        check("R4 pin release", dev_rst, 0);
        wr(7'h04);
        check("R9 pin flag set by write", flags[2], 1);

        // R4 pin disabled, then enabled by low-voltage programming bit
        cfg_pin_en = 1'b0;
        pin_lvl = 1'b0;
        cyc(4);
        check("R4 disabled pin no reset", dev_rst, 0);
        check("R4 disabled pin flag kept", flags[2], 1);
        cfg_lvp = 1'b1;
        cyc(1);
        check("R4 lvp enables pin reset", dev_rst, 1);
        cyc(1);
        check("R4 lvp pin flag cleared", flags[2], 0);
        pin_lvl = 1'b1; cfg_lvp = 1'b0; cfg_pin_en = 1'b1;
        cyc(3);
        wr(7'h3F);

        // R10 pin beats watchdog, brown-out beats pin
        pin_lvl = 1'b0;
        cyc(3);
        wdt_tmo = 1'b1; cyc(1); wdt_tmo = 1'b0;
        check("R10 watchdog masked by pin (timeout)", flags[4], 1);
        check("R10 watchdog masked by pin (wdt flag)", flags[3], 1);
        bor_raw = 1'b1;
        cyc(3);
        check("R3 brown-out flag cleared", flags[1], 0);
        wr(7'h04);
        check("R10 pin ignored under brown-out", flags[2], 1);
        bor_raw = 1'b0;
        cyc(3);
        check("R10 pin acts after brown-out", flags[2], 0);
        pin_lvl = 1'b1;
        cyc(P + 4);
        check("R6 released after brown-out delay", dev_rst, 0);
        wr(7'h3F);

        // R2 combined brown-out
        for (int k = 0; k < 8; k++) begin
            {bor_raw, lpbor_raw, cfg_lpbor_off} = 3'(k);
            #1;
            check("R2 combined brown-out", bor_comb, (k[2] | (k[1] & ~k[0])));
            cyc(1);
        end
        bor_raw = 1'b0; lpbor_raw = 1'b0; cfg_lpbor_off = 1'b1;
        cyc(P + 4);
        check("R2 settle after combos", dev_rst, 0);
        wr(7'h3F);

        // R3 low-power brown-out path
        cfg_lpbor_off = 1'b0; lpbor_raw = 1'b1;
        cyc(1);
        check("R3 not yet synced", dev_rst, 0);
        cyc(1);
        check("R3 reset at second edge", dev_rst, 1);
        cyc(1);
        check("R3 flag from low-power path", flags[1], 0);
        lpbor_raw = 1'b0; cfg_lpbor_off = 1'b1;

        // R7 restart on brown-out during delay
        cyc(P / 2);
        check("R7 delay running", dev_rst, 1);
        bor_raw = 1'b1;
        cyc(4);
        bor_raw = 1'b0;
        cyc(P + 1);
        check("R7 restarted delay held", dev_rst, 1);
        cyc(1);
        check("R7 restarted delay ends", dev_rst, 0);

        // R6 timer disabled
        cfg_pwrt_off = 1'b1;
        bor_raw = 1'b1;
        cyc(3);
        bor_raw = 1'b0;
        cyc(1);
        check("R6 disabled still held", dev_rst, 1);
        cyc(1);
        check("R6 disabled release at second edge", dev_rst, 0);
        cfg_pwrt_off = 1'b0;
        wr(7'h3F);

        // R8 programming-mode exit
        prog_exit = 1'b1; cyc(1); prog_exit = 1'b0;
        check("R8 reset after exit", dev_rst, 1);
        cyc(1);
        check("R8 power-on flags", flags, 7'h3E);
        cyc(P);
        check("R8 held through delay", dev_rst, 1);
        cyc(1);
        check("R8 released", dev_rst, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule